// File: doc/BRIEF.md
# Per-Connection Interrupt Demultiplexer with Notification Queue

This block sits between the per-connection event sources of a multi-connection network interface and the host. Each connection has a one-shot interrupt arm. An event on an armed connection raises the shared host interrupt and disarms that connection at once. Any further events on that connection then stay silent until the host re-arms it with a command write. A descriptor read whose interrupt flag is set interrupts unconditionally and leaves the arm alone.

Besides deciding on the interrupt, every event is posted to an on-chip notification queue. Each entry is a connection number together with that connection's latest status code. A per-connection pending bit keeps each connection to at most one entry, so the depth equals the connection count and the queue cannot overflow. The interrupt service routine pops entries until the queue is empty and so learns which connections were active, without walking every descriptor chain.

The interrupt line is controlled by a two-state machine. In IRQ_IDLE the line is low, and the machine moves to IRQ_ACTIVE when any cause occurs. In IRQ_ACTIVE the line is high. The machine returns to IRQ_IDLE on a host acknowledge, but only if no new cause occurs in the same cycle; otherwise it stays in IRQ_ACTIVE.

Top module: `evt_notify_ctrl`

## Requirements
- R1: After reset, irq is low, q_valid is low and every connection is armed.
- R2: An event on an armed connection sets irq from the next cycle and disarms that connection.
- R3: An event on a disarmed connection raises no interrupt, while an event on an armed connection still does.
- R4: A command write on cmd_conn re-arms that connection, so its next event interrupts.
- R5: When an event and a re-arm command hit the same connection in the same cycle, the event takes priority: one interrupt is raised and the connection ends up disarmed.
- R6: A descriptor read with desc_intr high interrupts whatever the arm state, leaves the arm unchanged and posts code DESC_CODE (default 4'hF). A descriptor read with desc_intr low has no effect.
- R7: Each queue entry shows the connection on q_conn and that connection's code on q_code. Entries appear in the order of first activity. When an event and a descriptor read on different connections arrive in the same cycle, the event's entry comes first.
- R8: A connection holds at most one entry. A later event on a connection that already has an entry replaces the stored code and adds no new entry.
- R9: A pop (q_rd while q_valid) removes the head entry and clears its pending bit, so a later event on that connection posts it again. If an event on the head connection arrives in the same cycle as the pop, that connection is posted again at the tail.
- R10: irq stays high until irq_ack. If a new cause arrives in the same cycle as the acknowledge, irq stays high.
- R11: All NUM_CONN connections can hold an entry at the same time, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Connection event strobe |
| evt_conn | input | CONN_W | Connection of the event |
| evt_code | input | CODE_W | Status code of the event |
| desc_valid | input | 1 | Descriptor-read strobe |
| desc_conn | input | CONN_W | Connection of the descriptor |
| desc_intr | input | 1 | Interrupt flag of the descriptor read |
| cmd_wr | input | 1 | Re-arm command write |
| cmd_conn | input | CONN_W | Connection to re-arm |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| q_rd | input | 1 | Pop the head notification |
| irq | output | 1 | Host interrupt line |
| q_valid | output | 1 | Queue holds at least one entry |
| q_conn | output | CONN_W | Connection of the head entry |
| q_code | output | CODE_W | Current code of the head connection |

## Verification
The checker assumes that evt_conn, desc_conn and cmd_conn always name connections below NUM_CONN, and that each strobe lasts exactly one cycle per event. The bench drives only connection numbers in range and raises every strobe for a single cycle. It pops only when it has just seen q_valid high, except in a deliberate test that pops an empty queue. The pop-count property is conditioned on no push in the same cycle, so concurrent event and pop traffic is left to the bench's order checks.

// File: rtl/evt_notify_pkg.sv
package evt_notify_pkg;
    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_notify_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (cause) state_n = IRQ_ACTIVE;
            IRQ_ACTIVE: if (ack && !cause) state_n = IRQ_IDLE;
            default:    state_n = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/evt_conn_bank.sv
module evt_conn_bank #(
    parameter int NUM_CONN  = 16,
    parameter int CODE_W    = 4,
    parameter logic [CODE_W-1:0] DESC_CODE = '1,
    localparam int CONN_W   = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CONN_W-1:0] evt_conn,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              desc_valid,
    input  logic [CONN_W-1:0] desc_conn,
    input  logic              desc_intr,
    input  logic              cmd_wr,
    input  logic [CONN_W-1:0] cmd_conn,
    input  logic              pop,
    input  logic [CONN_W-1:0] head_conn,
    output logic              fire_evt,
    output logic              fire_desc,
    output logic              push_evt,
    output logic              push_desc,
    output logic [CODE_W-1:0] head_code,
    output logic [NUM_CONN-1:0] en_vec
);
    logic [NUM_CONN-1:0] en_q, en_n;
    logic [NUM_CONN-1:0] pend_q, pend_n, pend_eff;
    logic [CODE_W-1:0]   code_q [NUM_CONN];
    logic                desc_hit;
    logic                same_conn;

    assign desc_hit  = desc_valid && desc_intr;
    assign same_conn = evt_valid && (evt_conn == desc_conn);

    always_comb begin
        pend_eff = pend_q;
        if (pop) pend_eff[head_conn] = 1'b0;
    end

    always_comb begin
        fire_evt  = evt_valid && (en_q[evt_conn] || (cmd_wr && (cmd_conn == evt_conn)));
        fire_desc = desc_hit;
        push_evt  = evt_valid && !pend_eff[evt_conn];
        push_desc = desc_hit && !same_conn && !pend_eff[desc_conn];
    end

    always_comb begin
        en_n   = en_q;
        pend_n = pend_eff;
        if (cmd_wr)    en_n[cmd_conn]    = 1'b1;
        if (evt_valid) en_n[evt_conn]    = 1'b0;
        if (evt_valid) pend_n[evt_conn]  = 1'b1;
        if (desc_hit)  pend_n[desc_conn] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '1;
            pend_q <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CONN; i++) code_q[i] <= '0;
        end else begin
            if (desc_hit && !same_conn) code_q[desc_conn] <= DESC_CODE;
            if (evt_valid)              code_q[evt_conn]  <= evt_code;
        end
    end

    assign head_code = code_q[head_conn];
    assign en_vec    = en_q;
endmodule

// File: rtl/evt_notify_fifo.sv
module evt_notify_fifo #(
    parameter int NUM_CONN = 16,
    localparam int CONN_W  = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1,
    localparam int CNT_W   = $clog2(NUM_CONN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic [CONN_W-1:0] wr0_conn,
    input  logic              wr1,
    input  logic [CONN_W-1:0] wr1_conn,
    input  logic              rd,
    output logic              not_empty,
    output logic [CONN_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CONN_W-1:0] LAST = CONN_W'(NUM_CONN - 1);

    logic [CONN_W-1:0] slot_q [NUM_CONN];
    logic [CONN_W-1:0] wp_q, rp_q, wp_a, wp_b;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_rd;
    logic [1:0]        n_wr;

    function automatic logic [CONN_W-1:0] nxt(input logic [CONN_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_rd = rd && (cnt_q != '0);
    assign n_wr  = {1'b0, wr0} + {1'b0, wr1};
    assign wp_a  = wp_q;
    assign wp_b  = wr0 ? nxt(wp_q) : wp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr0) slot_q[wp_a] <= wr0_conn;
            if (wr1) slot_q[wp_b] <= wr1_conn;
            case (n_wr)
                2'd1:    wp_q <= nxt(wp_q);
                2'd2:    wp_q <= nxt(nxt(wp_q));
                default: wp_q <= wp_q;
            endcase
            if (do_rd) rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CNT_W'(n_wr) - CNT_W'(do_rd);
        end
    end

    assign not_empty = (cnt_q != '0);
    assign head      = slot_q[rp_q];
    assign count     = cnt_q;
endmodule

// File: rtl/evt_notify_ctrl.sv
module evt_notify_ctrl #(
    parameter int NUM_CONN = 16,
    parameter int CODE_W   = 4,
    parameter logic [CODE_W-1:0] DESC_CODE = '1,
    localparam int CONN_W  = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1,
    localparam int CNT_W   = $clog2(NUM_CONN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CONN_W-1:0] evt_conn,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              desc_valid,
    input  logic [CONN_W-1:0] desc_conn,
    input  logic              desc_intr,
    input  logic              cmd_wr,
    input  logic [CONN_W-1:0] cmd_conn,
    input  logic              irq_ack,
    input  logic              q_rd,
    output logic              irq,
    output logic              q_valid,
    output logic [CONN_W-1:0] q_conn,
    output logic [CODE_W-1:0] q_code
);
    logic fire_evt, fire_desc, push_evt, push_desc, cause, pop, fifo_ne;
    logic [CONN_W-1:0]   head;
    logic [CNT_W-1:0]    q_count;
    logic [NUM_CONN-1:0] en_vec;
    logic                wr0, wr1;
    logic [CONN_W-1:0]   wr0_conn;

    assign pop      = q_rd && fifo_ne;
    assign cause    = fire_evt || fire_desc;
    assign wr0      = push_evt || push_desc;
    assign wr0_conn = push_evt ? evt_conn : desc_conn;
    assign wr1      = push_evt && push_desc;

    evt_conn_bank #(.NUM_CONN(NUM_CONN), .CODE_W(CODE_W), .DESC_CODE(DESC_CODE)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_conn(evt_conn), .evt_code(evt_code),
        .desc_valid(desc_valid), .desc_conn(desc_conn), .desc_intr(desc_intr),
        .cmd_wr(cmd_wr), .cmd_conn(cmd_conn),
        .pop(pop), .head_conn(head),
        .fire_evt(fire_evt), .fire_desc(fire_desc),
        .push_evt(push_evt), .push_desc(push_desc),
        .head_code(q_code), .en_vec(en_vec)
    );

    evt_notify_fifo #(.NUM_CONN(NUM_CONN)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr0(wr0), .wr0_conn(wr0_conn),
        .wr1(wr1), .wr1_conn(desc_conn),
        .rd(q_rd), .not_empty(fifo_ne), .head(head), .count(q_count)
    );

    evt_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n), .cause(cause), .ack(irq_ack), .irq(irq)
    );

    assign q_valid = fifo_ne;
    assign q_conn  = head;
endmodule

// File: rtl/evt_notify_chk.sv
module evt_notify_chk #(
    parameter int NUM_CONN = 16,
    localparam int CONN_W  = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1,
    localparam int CNT_W   = $clog2(NUM_CONN + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                irq_ack,
    input logic                cause,
    input logic                evt_valid,
    input logic [CONN_W-1:0]   evt_conn,
    input logic [NUM_CONN-1:0] en_vec,
    input logic                q_rd,
    input logic                q_valid,
    input logic [CNT_W-1:0]    q_count,
    input logic                push_any
);
    assert_cause_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> irq);

    assert_rise_needs_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cause));

    assert_event_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !en_vec[$past(evt_conn)]);

    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(NUM_CONN));

    assert_pop_removes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_rd && q_valid && !push_any) |=> (q_count == $past(q_count) - 1'b1));
endmodule

bind evt_notify_ctrl evt_notify_chk #(.NUM_CONN(NUM_CONN)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_ack(irq_ack), .cause(cause),
    .evt_valid(evt_valid), .evt_conn(evt_conn), .en_vec(en_vec),
    .q_rd(q_rd), .q_valid(q_valid), .q_count(q_count), .push_any(wr0)
);

// File: tb/evt_notify_ctrl_tb.sv
module evt_notify_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 0, desc_valid = 0, desc_intr = 0, cmd_wr = 0, irq_ack = 0, q_rd = 0;
    logic [3:0] evt_conn = 0, evt_code = 0, desc_conn = 0, cmd_conn = 0;
    logic irq, q_valid;
    logic [3:0] q_conn, q_code;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    evt_notify_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_conn(evt_conn), .evt_code(evt_code),
        .desc_valid(desc_valid), .desc_conn(desc_conn), .desc_intr(desc_intr),
        .cmd_wr(cmd_wr), .cmd_conn(cmd_conn), .irq_ack(irq_ack), .q_rd(q_rd),
        .irq(irq), .q_valid(q_valid), .q_conn(q_conn), .q_code(q_code)
    );

    typedef struct packed {
        logic       ev;
        logic [3:0] ec;
        logic [3:0] ecode;
        logic       cmd;
        logic [3:0] cc;
        logic       ack;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd3, 4'd5, 1'b0, 4'd0, 1'b0, 1'b1},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0},
        '{1'b1, 4'd3, 4'd7, 1'b0, 4'd0, 1'b0, 1'b0},
        '{1'b1, 4'd4, 4'd1, 1'b0, 4'd0, 1'b0, 1'b1},
        '{1'b1, 4'd5, 4'd2, 1'b0, 4'd0, 1'b1, 1'b1},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0},
        '{1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 1'b0, 1'b0},
        '{1'b1, 4'd3, 4'd9, 1'b0, 4'd0, 1'b0, 1'b1},
        '{1'b1, 4'd6, 4'd3, 1'b1, 4'd6, 1'b1, 1'b1},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0},
        '{1'b1, 4'd6, 4'hA, 1'b0, 4'd0, 1'b0, 1'b0},
        '{1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic ev, input logic [3:0] ec, input logic [3:0] ecode,
                         input logic dv, input logic [3:0] dc, input logic df,
                         input logic cw, input logic [3:0] cc, input logic ak, input logic rd);
        evt_valid = ev; evt_conn = ec; evt_code = ecode;
        desc_valid = dv; desc_conn = dc; desc_intr = df;
        cmd_wr = cw; cmd_conn = cc; irq_ack = ak; q_rd = rd;
        @(posedge clk); #1;
        evt_valid = 0; desc_valid = 0; desc_intr = 0; cmd_wr = 0; irq_ack = 0; q_rd = 0;
    endtask

    task automatic pop_check(input string tag, input int exp_conn, input int exp_code);
        check({tag, " q_valid"}, int'(q_valid), 1);
        check({tag, " q_conn"}, int'(q_conn), exp_conn);
        check({tag, " q_code"}, int'(q_code), exp_code);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic ack();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq after reset", int'(irq), 0);
        check("R1 q_valid after reset", int'(q_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 R3 R4 R5 R10 via vector table (R1 arm state seen in first vector)
        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i].ev, VEC[i].ec, VEC[i].ecode, 0, 0, 0,
                  VEC[i].cmd, VEC[i].cc, VEC[i].ack, 0);
            check($sformatf("R2/R3/R4/R5/R10 vector %0d irq", i), int'(irq), int'(VEC[i].exp_irq));
        end

        // R7 R8 order and latest code
        pop_check("R7 R8 entry0", 3, 9);
        pop_check("R7 entry1", 4, 1);
        pop_check("R7 entry2", 5, 2);
        pop_check("R8 entry3", 6, 10);
        check("R9 empty after drain", int'(q_valid), 0);

        // R9 repost after pop
        cycle(1, 3, 4, 0, 0, 0, 0, 0, 0, 0);
        check("R3 disarmed conn3 irq", int'(irq), 0);
        pop_check("R9 repost", 3, 4);

        // R6 descriptor flag
        cycle(0, 0, 0, 1, 3, 1, 0, 0, 0, 0);
        check("R6 desc irq on disarmed", int'(irq), 1);
        ack();
        check("R10 ack clears", int'(irq), 0);
        cycle(1, 3, 2, 0, 0, 0, 0, 0, 0, 0);
        check("R6 arm unchanged", int'(irq), 0);
        pop_check("R6 R8 desc entry updated", 3, 2);
        cycle(0, 0, 0, 1, 7, 0, 0, 0, 0, 0);
        check("R6 no-flag desc irq", int'(irq), 0);
        check("R6 no-flag desc queue", int'(q_valid), 0);

        // R7 same-cycle event and descriptor
        cycle(1, 8, 6, 1, 9, 1, 0, 0, 0, 0);
        check("R2 conn8 irq", int'(irq), 1);
        pop_check("R7 event first", 8, 6);
        pop_check("R6 R7 desc second", 9, 15);
        ack();

        // R9 pop with same-cycle event on head
        cycle(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cycle(1, 2, 2, 0, 0, 0, 0, 0, 0, 0);
        check("R9 head before", int'(q_conn), 1);
        cycle(1, 1, 5, 0, 0, 0, 0, 0, 0, 1);
        pop_check("R9 next head", 2, 2);
        pop_check("R9 reposted tail", 1, 5);
        check("R9 empty", int'(q_valid), 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 pop on empty", int'(q_valid), 0);
        ack();
        check("R10 idle", int'(irq), 0);

        // R11 capacity
        for (int c = 0; c < 16; c++) cycle(1, 4'(c), 4'(c), 0, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < 16; c++) pop_check($sformatf("R11 slot %0d", c), c, c);
        check("R11 empty after full drain", int'(q_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule